// File: doc/BRIEF.md
# I2C Multi-Master Collision Guard

This block drives the SCL and SDA lines of an I2C master that shares the bus with other masters. It detects when another master wins the bus and recovers cleanly. A small sequencer generates start, repeated start, stop and acknowledge sequences and shifts transmit bytes out MSB first. The block compares every bit it leaves released (high) against the sampled SDA level while SCL is high. If the master releases SDA but reads it low, the master has lost arbitration. The block then drops every pending request, empties the transmit buffer, releases both lines and raises the interrupt.

After a loss the block keeps watching the bus. Start and stop conditions on the bus update two status flags, `s_o` and `p_o`. A stop condition raises the interrupt again, so software learns when the bus is free. Software then issues a new start and rewrites the buffer. That byte always goes out from its first bit. A start request made while another master holds the bus is refused and reported as a collision.

Timing uses a fixed half-period of `HALF_CYC` clocks per bus step. The inputs `scl_i` and `sda_i` are the already-synchronized line levels. The outputs `scl_oe_o` and `sda_oe_o` are open-drain pull-down enables, where 1 means the line is driven low.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset both pull-down enables are 0, and `bf_o`, `req_o`, `s_o`, `p_o` and `irq_o` are all 0.
- R2: A start request sets `req_o[0]`. The sequence pulls SDA low while SCL is high, then holds SCL and SDA low. When it completes, `req_o[0]` clears, `s_o`=1 and `p_o`=0.
- R3: A write with `bf_o`=0 loads the buffer and sets `bf_o`. A write while `bf_o`=1 is ignored. The byte is sent MSB first, and SDA changes only while SCL is low. `bf_o` clears when the last bit completes.
- R4: A stop request (`req_o[2]`) ends with both lines released. A stop condition seen on the bus (SDA rising while SCL is high) sets `p_o`=1, `s_o`=0 and `irq_o`=1. A start condition seen on the bus sets `s_o`=1 and `p_o`=0.
- R5: SDA is compared only in the first clock of a step where the block releases both SDA and SCL and `scl_i` is high. SDA pulled low by another master while SCL is low is never a collision.
- R6: A collision during a byte clears `bf_o`, releases both lines on the next clock and sets `irq_o`.
- R7: A collision during a start, repeated start (`req_o[1]`), stop or acknowledge (`req_o[3]`) sequence aborts it, clears its request bit and releases both lines.
- R8: After a collision, a stop condition on the bus sets `irq_o` again and sets `p_o`.
- R9: The first byte written after a collision is sent complete, starting from its MSB.
- R10: A start request while `s_o`=1 and `p_o`=0 is refused: `req_o` stays 0, the lines are released and `irq_o` is set.
- R11: `irq_o` stays 1 until `irq_clr_i` is pulsed. A set event in the same clock takes priority over the clear.
- R12: An acknowledge request drives the level given by `ack_bit_i`. Driving 0 (ACK) never causes a collision. Driving 1 (NACK) against a low SDA does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Transmit buffer write strobe |
| wr_data_i | input | DATA_W | Byte to transmit |
| start_req_i | input | 1 | Request a start sequence |
| rstart_req_i | input | 1 | Request a repeated start |
| stop_req_i | input | 1 | Request a stop sequence |
| ack_req_i | input | 1 | Request an acknowledge bit |
| ack_bit_i | input | 1 | Acknowledge level, 0 = ACK, 1 = NACK |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| bf_o | output | 1 | Transmit buffer full |
| req_o | output | 4 | Pending requests: [0] start, [1] repeated start, [2] stop, [3] acknowledge |
| s_o | output | 1 | Last bus event was a start |
| p_o | output | 1 | Last bus event was a stop |
| irq_o | output | 1 | Interrupt flag |

## Verification
Another master is modelled by pulling the wired-AND lines low at chosen moments. The bench injects a loss in the middle of a byte, during start, repeated start, stop and NACK, and as a start request while the bus is busy. A design that compared SDA during the SCL-low phase would flag a false loss on a short pull-low between bits. A design that kept the bit index across the abort would send a truncated next byte. After each loss the bench releases SDA and expects the stop to be seen. It also drives a low ACK against a low line and expects no loss. Missing line release or stale request bits show directly at the ports.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_START,
    OP_RSTART,
    OP_STOP,
    OP_ACK,
    OP_BYTE
  } op_e;

  localparam int unsigned REQ_W = 4;
  localparam int unsigned REQ_START  = 0;
  localparam int unsigned REQ_RSTART = 1;
  localparam int unsigned REQ_STOP   = 2;
  localparam int unsigned REQ_ACK    = 3;
endpackage

// File: rtl/i2c_step_timer.sv
module i2c_step_timer #(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned SW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [SW-1:0] step_o,
  output logic          first_o,
  output logic          end_o
);
  localparam int unsigned CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      step_q <= step_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_o  = step_q;
  assign first_o = run_i && (cnt_q == '0);
  assign end_o   = run_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/i2c_line_plan.sv
// Per-step line levels and compare points for each sequence
module i2c_line_plan
  import i2c_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SW     = 4
) (
  input  op_e               op_i,
  input  logic [SW-1:0]     step_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_bit_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              chk_o,
  output logic              last_o
);
  localparam int unsigned BYTE_STEPS = 2 * DATA_W;

  logic              cur_bit;
  logic [SW-2:0]     bit_idx;

  assign bit_idx = step_i[SW-1:1];
  assign cur_bit = data_i[DATA_W-1-int'(bit_idx)];

  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    chk_o     = 1'b0;
    last_o    = 1'b0;
    unique case (op_i)
      OP_START: begin
        last_o = (step_i == SW'(2));
        unique case (step_i)
          SW'(0):  chk_o = 1'b1;
          SW'(1):  sda_low_o = 1'b1;
          default: begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
        endcase
      end
      OP_RSTART: begin
        last_o = (step_i == SW'(3));
        unique case (step_i)
          SW'(0):  scl_low_o = 1'b1;
          SW'(1):  chk_o = 1'b1;
          SW'(2):  sda_low_o = 1'b1;
          default: begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
        endcase
      end
      OP_STOP: begin
        last_o = (step_i == SW'(2));
        unique case (step_i)
          SW'(0):  begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
          SW'(1):  sda_low_o = 1'b1;
          default: chk_o = 1'b1;
        endcase
      end
      OP_ACK: begin
        last_o    = (step_i == SW'(1));
        sda_low_o = !ack_bit_i;
        scl_low_o = (step_i == SW'(0));
        chk_o     = (step_i == SW'(1)) && ack_bit_i;
      end
      OP_BYTE: begin
        last_o    = (step_i == SW'(BYTE_STEPS - 1));
        scl_low_o = !step_i[0];
        sda_low_o = !cur_bit;
        chk_o     = step_i[0] && cur_bit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_bus_watch.sv
// Start/stop condition detector with S/P status
module i2c_bus_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_det_o,
  output logic stop_det_o,
  output logic s_o,
  output logic p_o
);
  logic scl_q, sda_q, s_q, p_q;

  // require SCL high on both samples so simultaneous line changes are not events
  assign start_det_o = scl_i && scl_q && sda_q && !sda_i;
  assign stop_det_o  = scl_i && scl_q && !sda_q && sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      s_q   <= 1'b0;
      p_q   <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det_o) begin
        s_q <= 1'b1;
        p_q <= 1'b0;
      end else if (stop_det_o) begin
        s_q <= 1'b0;
        p_q <= 1'b1;
      end
    end
  end

  assign s_o = s_q;
  assign p_o = p_q;
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
  import i2c_arb_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_req_i,
  input  logic              rstart_req_i,
  input  logic              stop_req_i,
  input  logic              ack_req_i,
  input  logic              ack_bit_i,
  input  logic              irq_clr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              bf_o,
  output logic [3:0]        req_o,
  output logic              s_o,
  output logic              p_o,
  output logic              irq_o
);
  localparam int unsigned SW = $clog2(2 * DATA_W);

  op_e               op_q, nxt_op;
  logic [DATA_W-1:0] buf_q;
  logic              bf_q, own_q, irq_q, ack_q;
  logic [REQ_W-1:0]  req_q, req_set, req_done;

  logic [SW-1:0] step;
  logic          step_first, step_end;
  logic          plan_scl_low, plan_sda_low, plan_chk, plan_last;
  logic          start_det, stop_det, s_flag, p_flag;
  logic          chk_fail, start_refused, conflict, op_done, op_act;

  assign op_act = (op_q != OP_IDLE);

  i2c_step_timer #(.HALF_CYC(HALF_CYC), .SW(SW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (op_act),
    .step_o  (step),
    .first_o (step_first),
    .end_o   (step_end)
  );

  i2c_line_plan #(.DATA_W(DATA_W), .SW(SW)) u_plan (
    .op_i      (op_q),
    .step_i    (step),
    .data_i    (buf_q),
    .ack_bit_i (ack_q),
    .scl_low_o (plan_scl_low),
    .sda_low_o (plan_sda_low),
    .chk_o     (plan_chk),
    .last_o    (plan_last)
  );

  i2c_bus_watch u_watch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_det_o (start_det),
    .stop_det_o  (stop_det),
    .s_o         (s_flag),
    .p_o         (p_flag)
  );

  // released-high bit read back low at the compare point
  assign chk_fail      = op_act && step_first && plan_chk && scl_i && !sda_i;
  assign start_refused = start_req_i && s_flag && !p_flag;
  assign conflict      = chk_fail || start_refused;
  assign op_done       = op_act && step_end && plan_last && !chk_fail;

  assign req_set = {ack_req_i, stop_req_i, rstart_req_i, start_req_i};

  always_comb begin
    req_done = '0;
    if (op_done) begin
      unique case (op_q)
        OP_START:  req_done[REQ_START]  = 1'b1;
        OP_RSTART: req_done[REQ_RSTART] = 1'b1;
        OP_STOP:   req_done[REQ_STOP]   = 1'b1;
        OP_ACK:    req_done[REQ_ACK]    = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (req_q[REQ_START])       nxt_op = OP_START;
    else if (req_q[REQ_RSTART]) nxt_op = OP_RSTART;
    else if (req_q[REQ_STOP])   nxt_op = OP_STOP;
    else if (req_q[REQ_ACK])    nxt_op = OP_ACK;
    else if (bf_q)              nxt_op = OP_BYTE;
    else                        nxt_op = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      req_q <= '0;
      bf_q  <= 1'b0;
      buf_q <= '0;
      own_q <= 1'b0;
      ack_q <= 1'b0;
    end else if (conflict) begin
      op_q  <= OP_IDLE;
      req_q <= '0;
      bf_q  <= 1'b0;
      own_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~req_done) | req_set;
      if (ack_req_i) ack_q <= ack_bit_i;
      if (wr_i && !bf_q) begin
        buf_q <= wr_data_i;
        bf_q  <= 1'b1;
      end
      if (!op_act) begin
        op_q <= nxt_op;
      end else if (op_done) begin
        op_q  <= OP_IDLE;
        own_q <= (op_q != OP_STOP);
        if (op_q == OP_BYTE) bf_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_q <= 1'b0;
    else if (conflict || stop_det) irq_q <= 1'b1;
    else if (irq_clr_i)            irq_q <= 1'b0;
  end

  assign scl_oe_o = op_act ? plan_scl_low : own_q;
  assign sda_oe_o = op_act ? plan_sda_low : own_q;
  assign bf_o     = bf_q;
  assign req_o    = req_q;
  assign s_o      = s_flag;
  assign p_o      = p_flag;
  assign irq_o    = irq_q;

  logic unused_ok;
  assign unused_ok = start_det;
endmodule

// File: rtl/i2c_arb_guard_chk.sv
module i2c_arb_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conflict_i,
  input logic       stop_det_i,
  input logic       byte_act_i,
  input logic       irq_clr_i,
  input logic       irq_o,
  input logic       bf_o,
  input logic [3:0] req_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       s_o,
  input logic       p_o
);
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |=> (!scl_oe_o && !sda_oe_o));

  p_bf_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |=> !bf_o);

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |=> irq_o);

  p_req_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |=> (req_o == 4'b0000));

  p_stop_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> (irq_o && p_o));

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  p_sp_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_o && p_o));

  p_sda_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_act_i && $past(byte_act_i) && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));
endmodule

bind i2c_arb_guard i2c_arb_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .conflict_i (conflict),
  .stop_det_i (stop_det),
  .byte_act_i (op_q == i2c_arb_pkg::OP_BYTE),
  .irq_clr_i  (irq_clr_i),
  .irq_o      (irq_o),
  .bf_o       (bf_o),
  .req_o      (req_o),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .s_o        (s_o),
  .p_o        (p_o)
);

// File: tb/i2c_arb_guard_test.sv
module i2c_arb_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, start_req = 1'b0, rstart_req = 1'b0, stop_req = 1'b0;
  logic       ack_req = 1'b0, ack_bit = 1'b0, irq_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ext_scl = 1'b1, ext_sda = 1'b1;
  logic       scl_bus, sda_bus, scl_oe, sda_oe, bf, s_f, p_f, irq;
  logic [3:0] req;

  int total = 0;
  int bad   = 0;

  logic [7:0] cap;
  int         cap_n = 0;
  logic       scl_prev = 1'b1;

  always #4 clk = ~clk;

  assign scl_bus = !scl_oe && ext_scl;
  assign sda_bus = !sda_oe && ext_sda;

  i2c_arb_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wr_data),
    .start_req_i(start_req), .rstart_req_i(rstart_req), .stop_req_i(stop_req),
    .ack_req_i(ack_req), .ack_bit_i(ack_bit), .irq_clr_i(irq_clr),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .bf_o(bf), .req_o(req), .s_o(s_f), .p_o(p_f), .irq_o(irq)
  );

  // bit capture on every SCL rise
  always @(negedge clk) begin
    if (scl_bus && !scl_prev) begin
      cap   <= {cap[6:0], sda_bus};
      cap_n <= cap_n + 1;
    end
    scl_prev <= scl_bus;
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    ext_scl = 1'b1; ext_sda = 1'b1;
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(2);
  endtask

  task automatic pulse_start();  start_req = 1'b1;  cyc(1); start_req = 1'b0;  endtask
  task automatic pulse_rstart(); rstart_req = 1'b1; cyc(1); rstart_req = 1'b0; endtask
  task automatic pulse_stop();   stop_req = 1'b1;   cyc(1); stop_req = 1'b0;   endtask
  task automatic pulse_clr();    irq_clr = 1'b1;    cyc(1); irq_clr = 1'b0;    endtask
  task automatic pulse_ack(input logic b);
    ack_bit = b; ack_req = 1'b1; cyc(1); ack_req = 1'b0;
  endtask
  task automatic write_byte(input logic [7:0] d);
    wr_data = d; wr = 1'b1; cyc(1); wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {bf, req, s_f, p_f, irq}, 0);
  endtask

  task automatic t_start_byte_stop();
    do_reset();
    pulse_start();
    chk("R2 req pending", req, 1);
    cyc(40);
    chk("R2 req done", req, 0);
    chk("R2 s/p", {s_f, p_f}, 2'b10);
    chk("R2 hold lines", {scl_oe, sda_oe}, 2'b11);
    cap_n = 0;
    write_byte(8'hB5);
    write_byte(8'h00);
    chk("R3 bf set", bf, 1);
    cyc(100);
    chk("R3 bits", cap, 8'hB5);
    chk("R3 count", cap_n, 8);
    chk("R3 bf cleared", bf, 0);
    chk("R3 no irq", irq, 0);
    pulse_stop();
    cyc(40);
    chk("R4 released", {scl_oe, sda_oe}, 2'b00);
    chk("R4 s/p", {s_f, p_f}, 2'b01);
    chk("R4 irq on stop", irq, 1);
    chk("R4 req done", req, 0);
    cyc(20);
    chk("R11 irq held", irq, 1);
    pulse_clr();
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_byte_conflict();
    do_reset();
    pulse_start(); cyc(40);
    cap_n = 0;
    write_byte(8'hB5);
    // wait for low phase of third bit (value 1), then another master pulls SDA
    while (!(cap_n == 2 && scl_oe)) cyc(1);
    ext_sda = 1'b0;
    cyc(12);
    chk("R6 irq", irq, 1);
    chk("R6 bf cleared", bf, 0);
    chk("R6 released", {scl_oe, sda_oe}, 2'b00);
    chk("R6 bits before loss", {cap_n, 5'b0, cap[2:0]}, {32'd3, 5'b0, 3'b100});
    pulse_clr();
    chk("R8 irq cleared", irq, 0);
    cyc(4);
    ext_sda = 1'b1;
    cyc(3);
    chk("R8 irq on stop", irq, 1);
    chk("R8 p set", {s_f, p_f}, 2'b01);
    pulse_clr();
    pulse_start(); cyc(40);
    chk("R9 start ok", irq, 0);
    cap_n = 0;
    write_byte(8'hC3);
    cyc(100);
    chk("R9 full byte from MSB", cap, 8'hC3);
    chk("R9 bit count", cap_n, 8);
  endtask

  task automatic t_no_check_low();
    do_reset();
    pulse_start(); cyc(40);
    cap_n = 0;
    write_byte(8'hFF);
    while (!(cap_n == 3 && scl_oe)) cyc(1);
    ext_sda = 1'b0; cyc(1); ext_sda = 1'b1;
    cyc(100);
    chk("R5 no loss on low phase", irq, 0);
    chk("R5 byte intact", cap, 8'hFF);
  endtask

  task automatic t_start_conflict();
    do_reset();
    ext_scl = 1'b0; cyc(2); ext_sda = 1'b0; cyc(2); ext_scl = 1'b1; cyc(2);
    chk("R7 no bus event", {s_f, p_f, irq}, 0);
    pulse_start();
    cyc(20);
    chk("R7 start aborted irq", irq, 1);
    chk("R7 start req cleared", req, 0);
    chk("R7 start released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_rstart_stop_conflict();
    do_reset();
    pulse_start(); cyc(40);
    ext_sda = 1'b0;
    pulse_rstart();
    chk("R7 rstart pending", req, 2);
    cyc(40);
    chk("R7 rstart irq", irq, 1);
    chk("R7 rstart req cleared", req, 0);
    chk("R7 rstart released", {scl_oe, sda_oe}, 2'b00);
    do_reset();
    pulse_start(); cyc(40);
    ext_sda = 1'b0;
    pulse_stop();
    chk("R7 stop pending", req, 4);
    cyc(40);
    chk("R7 stop irq", irq, 1);
    chk("R7 stop req cleared", req, 0);
    chk("R7 stop released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_ack();
    do_reset();
    pulse_start(); cyc(40);
    ext_sda = 1'b0;
    pulse_ack(1'b0);
    cyc(30);
    chk("R12 ack low no loss", irq, 0);
    chk("R12 ack done", req, 0);
    chk("R12 holds bus", scl_oe, 1);
    pulse_ack(1'b1);
    chk("R12 nack pending", req, 8);
    cyc(30);
    chk("R12 nack loss", irq, 1);
    chk("R7 ack req cleared", req, 0);
  endtask

  task automatic t_refused();
    do_reset();
    pulse_start(); cyc(40);
    chk("R10 busy", {s_f, p_f}, 2'b10);
    pulse_start();
    cyc(2);
    chk("R10 irq", irq, 1);
    chk("R10 req not set", req, 0);
    chk("R10 released", {scl_oe, sda_oe}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_start_byte_stop();
    t_byte_conflict();
    t_no_check_low();
    t_start_conflict();
    t_rstart_stop_conflict();
    t_ack();
    t_refused();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule